// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block handles the descriptor bookkeeping for a receive path and a transmit path. Each path keeps its own circular list of two-word descriptors in memory. Each list starts at a queue base address supplied as an input. Every descriptor is 8 bytes long. The word at the lower address is the buffer-address word. The word at descriptor address + 4 is the status word. Data moves as 32-bit words. Buffers and descriptors live in word-addressed memory that is reached through byte addresses. Each path has its own read/write port, and a read returns its data in the same cycle.

On receive, an incoming word stream is placed into buffers that software has handed to the engine. A frame may span several descriptors. On transmit, a start pulse makes the engine walk the ring from its current position. It streams each buffer that software has released and hands every descriptor back after the buffer has been sent. Five sticky event flags report what happened. Software clears a flag by writing 1 to it.

Top module: `dring_engine`

## Requirements
- R1: After reset, all flags are 0, rx_ready and tx_valid are low, no memory write is issued, and both ring positions are at their queue bases.
- R2: Receive address word layout: bit 0 is ownership, bit 1 is wrap, and bits 31:2 give the word-aligned buffer base. The engine fills only a descriptor whose ownership bit is 0. It writes the frame words to consecutive word addresses from the buffer base. When it hands the descriptor back, it rewrites the address word with ownership set to 1.
- R3: Receive status word: bit 14 marks the first buffer of a frame, bit 15 marks the last buffer, and bits 12:0 hold the total frame length in words on the last buffer (0 on the other buffers).
- R4: A receive buffer holds BUF_WORDS words. A longer frame continues in the next descriptor.
- R5: After a descriptor whose wrap bit is set, the next descriptor used is the one at the queue base. Otherwise the next one is 8 bytes further on. This holds for both rings.
- R6: If the descriptor at frame start is owned by software, the whole frame is accepted from the stream and discarded. Flag bit 3 (no buffer) is set, nothing is written, and the ring position does not move. If this happens partway through a frame, flag bit 4 (overrun) is also set.
- R7: Flag bit 2 (receive done) is set after the last descriptor of a frame has been handed back.
- R8: The transmit engine stays idle until tx_start is pulsed. It then reads status words (bit 31 used, bit 30 wrap, bit 15 last buffer, bits 12:0 length in words) and stops at the first descriptor whose used bit is 1.
- R9: Each transmit buffer is streamed in address order. tx_last is high only on the final word of a buffer that has the last flag. While tx_ready is low, tx_data and tx_last are held.
- R10: After each buffer, its status word is rewritten with the used bit set and all other bits kept. Flag bit 0 (transmit done) is set after a buffer that has the last flag.
- R11: If a used descriptor is found after a buffer without the last flag, flag bit 1 (underrun) is set.
- R12: A 1 on a bit of flag_clr clears that flag. A 0 leaves the flag unchanged.
- R13: A transmit descriptor with length 0 sends no words but is still handed back and followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxq_base | input | 32 | Receive ring base byte address |
| txq_base | input | 32 | Transmit ring base byte address |
| tx_start | input | 1 | Start pulse for the transmit walk |
| rx_valid | input | 1 | Receive stream word valid |
| rx_data | input | 32 | Receive stream word |
| rx_last | input | 1 | Final word of the receive frame |
| rx_ready | output | 1 | Receive word accepted |
| tx_valid | output | 1 | Transmit stream word valid |
| tx_data | output | 32 | Transmit stream word |
| tx_last | output | 1 | Final word of the transmit frame |
| tx_ready | input | 1 | Transmit word taken by the sink |
| rxm_rd | output | 1 | Receive memory read strobe |
| rxm_we | output | 1 | Receive memory write strobe |
| rxm_addr | output | 32 | Receive memory byte address |
| rxm_wdata | output | 32 | Receive memory write data |
| rxm_rdata | input | 32 | Receive memory read data, same cycle |
| txm_rd | output | 1 | Transmit memory read strobe |
| txm_we | output | 1 | Transmit memory write strobe |
| txm_addr | output | 32 | Transmit memory byte address |
| txm_wdata | output | 32 | Transmit memory write data |
| txm_rdata | input | 32 | Transmit memory read data, same cycle |
| flag_clr | input | 5 | Write-1-to-clear mask for the flags |
| flags | output | 5 | Sticky flags: 0 tx done, 1 tx underrun, 2 rx done, 3 rx no buffer, 4 rx overrun |

## Verification
The checks take the following for granted:
- The memory answers a read in the same cycle it is issued.
- The queue bases are 8-byte aligned.
- Nothing rewrites a transmit buffer while its words are being streamed.
- Receive buffers, transmit buffers and descriptors occupy disjoint regions.

Under those conditions, held transmit data and the order of handback writes can be checked at the ports alone. The stimulus respects all of these conditions. It places the two rings and the buffers in separate address ranges. It changes memory from the bench only while both engines are idle, and it toggles back-pressure only on the transmit side.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 13;
    localparam int NFLAGS = 5;

    // receive descriptor bit positions
    localparam int RX_OWN_BIT  = 0;
    localparam int RX_WRAP_BIT = 1;
    localparam int RX_SOF_BIT  = 14;
    localparam int RX_EOF_BIT  = 15;

    // transmit status bit positions
    localparam int TX_USED_BIT = 31;
    localparam int TX_WRAP_BIT = 30;
    localparam int TX_LAST_BIT = 15;

    localparam logic [WORD_W-1:0] DESC_STEP = 32'd8;
    localparam logic [WORD_W-1:0] STAT_OFS  = 32'd4;

    // flag indices
    localparam int FL_TXDONE  = 0;
    localparam int FL_TXUND   = 1;
    localparam int FL_RXDONE  = 2;
    localparam int FL_RXNOBUF = 3;
    localparam int FL_RXOVR   = 4;

    typedef enum logic [2:0] {
        RX_IDLE, RX_FETCH, RX_DATA, RX_STAT, RX_OWN, RX_DROP
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_FETCH, TX_ADDR, TX_DATA, TX_WB
    } tx_state_e;

    typedef struct packed {
        logic             wrap;
        logic             last;
        logic [LEN_W-1:0] len;
    } tx_stat_t;

    function automatic logic [WORD_W-1:0] next_ofs(input logic [WORD_W-1:0] ofs,
                                                   input logic wrap);
        return wrap ? '0 : ofs + DESC_STEP;
    endfunction

    function automatic tx_stat_t unpack_tx(input logic [WORD_W-1:0] w);
        tx_stat_t s;
        s.wrap = w[TX_WRAP_BIT];
        s.last = w[TX_LAST_BIT];
        s.len  = w[LEN_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/dring_flags.sv
module dring_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else
                q[i] <= set[i] | (q[i] & ~clr[i]);
        end
    end
endmodule

// File: rtl/dring_rx.sv
module dring_rx
    import dring_pkg::*;
#(
    parameter int BUF_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] q_base,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              m_rd,
    output logic              m_we,
    output logic [WORD_W-1:0] m_addr,
    output logic [WORD_W-1:0] m_wdata,
    input  logic [WORD_W-1:0] m_rdata,
    output logic              ev_done,
    output logic              ev_nobuf,
    output logic              ev_ovr
);
    localparam int CNT_W = $clog2(BUF_WORDS + 1);

    rx_state_e         state;
    logic [WORD_W-1:0] ofs;
    logic [WORD_W-1:0] w0;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  tot;
    logic              first;
    logic              eof;

    logic [WORD_W-1:0] desc_addr;
    logic [WORD_W-1:0] buf_base;
    logic [WORD_W-1:0] stat_word;

    assign desc_addr = q_base + ofs;
    assign buf_base  = {w0[WORD_W-1:2], 2'b00};

    always_comb begin
        stat_word = '0;
        stat_word[RX_SOF_BIT] = first;
        stat_word[RX_EOF_BIT] = eof;
        if (eof)
            stat_word[LEN_W-1:0] = tot;
    end

    always_comb begin
        m_rd     = 1'b0;
        m_we     = 1'b0;
        m_addr   = desc_addr;
        m_wdata  = '0;
        in_ready = 1'b0;
        case (state)
            RX_FETCH: m_rd = 1'b1;
            RX_DATA: begin
                in_ready = 1'b1;
                m_we     = in_valid;
                m_addr   = buf_base + (WORD_W'(cnt) << 2);
                m_wdata  = in_data;
            end
            RX_STAT: begin
                m_we    = 1'b1;
                m_addr  = desc_addr + STAT_OFS;
                m_wdata = stat_word;
            end
            RX_OWN: begin
                m_we    = 1'b1;
                m_wdata = w0 | (WORD_W'(1) << RX_OWN_BIT);
            end
            RX_DROP: in_ready = 1'b1;
            default: ;
        endcase
    end

    assign ev_done  = (state == RX_OWN) && eof;
    assign ev_nobuf = (state == RX_FETCH) && m_rdata[RX_OWN_BIT];
    assign ev_ovr   = ev_nobuf && !first;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            ofs   <= '0;
            w0    <= '0;
            cnt   <= '0;
            tot   <= '0;
            first <= 1'b0;
            eof   <= 1'b0;
        end else begin
            case (state)
                RX_IDLE: if (in_valid) begin
                    state <= RX_FETCH;
                    first <= 1'b1;
                    tot   <= '0;
                end
                RX_FETCH: begin
                    if (m_rdata[RX_OWN_BIT]) begin
                        state <= RX_DROP;
                    end else begin
                        w0    <= m_rdata;
                        cnt   <= '0;
                        state <= RX_DATA;
                    end
                end
                RX_DATA: if (in_valid) begin
                    cnt <= cnt + CNT_W'(1);
                    tot <= tot + LEN_W'(1);
                    if (in_last) begin
                        eof   <= 1'b1;
                        state <= RX_STAT;
                    end else if (cnt == CNT_W'(BUF_WORDS - 1)) begin
                        eof   <= 1'b0;
                        state <= RX_STAT;
                    end
                end
                RX_STAT: state <= RX_OWN;
                RX_OWN: begin
                    ofs   <= next_ofs(ofs, w0[RX_WRAP_BIT]);
                    first <= 1'b0;
                    state <= eof ? RX_IDLE : RX_FETCH;
                end
                RX_DROP: if (in_valid && in_last) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dring_tx.sv
module dring_tx
    import dring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] q_base,
    input  logic              start,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              m_rd,
    output logic              m_we,
    output logic [WORD_W-1:0] m_addr,
    output logic [WORD_W-1:0] m_wdata,
    input  logic [WORD_W-1:0] m_rdata,
    output logic              ev_done,
    output logic              ev_und
);
    tx_state_e         state;
    logic [WORD_W-1:0] ofs;
    logic [WORD_W-1:0] stw;
    tx_stat_t          st;
    logic [WORD_W-1:0] bufa;
    logic [LEN_W-1:0]  cnt;
    logic              mid;

    logic [WORD_W-1:0] desc_addr;
    logic              at_end;

    assign desc_addr = q_base + ofs;
    assign at_end    = (cnt == st.len - LEN_W'(1));
    assign out_data  = m_rdata;

    always_comb begin
        m_rd      = 1'b0;
        m_we      = 1'b0;
        m_addr    = desc_addr;
        m_wdata   = '0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        case (state)
            TX_FETCH: begin
                m_rd   = 1'b1;
                m_addr = desc_addr + STAT_OFS;
            end
            TX_ADDR: m_rd = 1'b1;
            TX_DATA: begin
                m_rd      = 1'b1;
                m_addr    = bufa + (WORD_W'(cnt) << 2);
                out_valid = 1'b1;
                out_last  = st.last && at_end;
            end
            TX_WB: begin
                m_we    = 1'b1;
                m_addr  = desc_addr + STAT_OFS;
                m_wdata = stw | (WORD_W'(1) << TX_USED_BIT);
            end
            default: ;
        endcase
    end

    assign ev_done = (state == TX_WB) && st.last;
    assign ev_und  = (state == TX_FETCH) && m_rdata[TX_USED_BIT] && mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            ofs   <= '0;
            stw   <= '0;
            st    <= '0;
            bufa  <= '0;
            cnt   <= '0;
            mid   <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: if (start) state <= TX_FETCH;
                TX_FETCH: begin
                    if (m_rdata[TX_USED_BIT]) begin
                        mid   <= 1'b0;
                        state <= TX_IDLE;
                    end else begin
                        stw   <= m_rdata;
                        st    <= unpack_tx(m_rdata);
                        state <= TX_ADDR;
                    end
                end
                TX_ADDR: begin
                    bufa  <= m_rdata;
                    cnt   <= '0;
                    state <= (st.len == '0) ? TX_WB : TX_DATA;
                end
                TX_DATA: if (out_ready) begin
                    if (at_end)
                        state <= TX_WB;
                    else
                        cnt <= cnt + LEN_W'(1);
                end
                TX_WB: begin
                    ofs   <= next_ofs(ofs, st.wrap);
                    mid   <= !st.last;
                    state <= TX_FETCH;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dring_engine.sv
module dring_engine
    import dring_pkg::*;
#(
    parameter int BUF_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rxq_base,
    input  logic [WORD_W-1:0] txq_base,
    input  logic              tx_start,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              rxm_rd,
    output logic              rxm_we,
    output logic [WORD_W-1:0] rxm_addr,
    output logic [WORD_W-1:0] rxm_wdata,
    input  logic [WORD_W-1:0] rxm_rdata,
    output logic              txm_rd,
    output logic              txm_we,
    output logic [WORD_W-1:0] txm_addr,
    output logic [WORD_W-1:0] txm_wdata,
    input  logic [WORD_W-1:0] txm_rdata,
    input  logic [NFLAGS-1:0] flag_clr,
    output logic [NFLAGS-1:0] flags
);
    logic              rx_done, rx_nobuf, rx_ovr, tx_done, tx_und;
    logic [NFLAGS-1:0] flag_set;

    dring_rx #(.BUF_WORDS(BUF_WORDS)) rx_i (
        .clk(clk), .rst(rst), .q_base(rxq_base),
        .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last), .in_ready(rx_ready),
        .m_rd(rxm_rd), .m_we(rxm_we), .m_addr(rxm_addr), .m_wdata(rxm_wdata),
        .m_rdata(rxm_rdata),
        .ev_done(rx_done), .ev_nobuf(rx_nobuf), .ev_ovr(rx_ovr)
    );

    dring_tx tx_i (
        .clk(clk), .rst(rst), .q_base(txq_base), .start(tx_start),
        .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last), .out_ready(tx_ready),
        .m_rd(txm_rd), .m_we(txm_we), .m_addr(txm_addr), .m_wdata(txm_wdata),
        .m_rdata(txm_rdata),
        .ev_done(tx_done), .ev_und(tx_und)
    );

    always_comb begin
        flag_set             = '0;
        flag_set[FL_TXDONE]  = tx_done;
        flag_set[FL_TXUND]   = tx_und;
        flag_set[FL_RXDONE]  = rx_done;
        flag_set[FL_RXNOBUF] = rx_nobuf;
        flag_set[FL_RXOVR]   = rx_ovr;
    end

    dring_flags #(.N(NFLAGS)) flags_i (
        .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .q(flags)
    );
endmodule

// File: rtl/dring_chk.sv
module dring_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic [31:0] tx_data,
    input logic        tx_last,
    input logic        tx_ready,
    input logic        rxm_we,
    input logic [31:0] rxm_wdata,
    input logic        txm_we,
    input logic [31:0] txm_wdata,
    input logic [4:0]  flag_clr,
    input logic [4:0]  flags
);
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_tx_gap_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    p_tx_wb_used_r10: assert property (@(posedge clk) disable iff (rst)
        txm_we |-> txm_wdata[31]);

    p_tx_done_after_wb_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> $past(txm_we));

    p_rx_done_after_own_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> $past(rxm_we && rxm_wdata[0]));

    p_flags_only_w1c_r12: assert property (@(posedge clk) disable iff (rst)
        (($past(flags) & ~flags & ~$past(flag_clr)) == 5'b0));
endmodule

bind dring_engine dring_chk chk_i (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rxm_we(rxm_we), .rxm_wdata(rxm_wdata),
    .txm_we(txm_we), .txm_wdata(txm_wdata),
    .flag_clr(flag_clr), .flags(flags)
);

// File: tb/dring_engine_tb_top.sv
`timescale 1ns/1ps
module dring_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rxq_base = 32'h000;
    logic [31:0] txq_base = 32'h040;
    logic        tx_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data  = '0;
    logic        rx_last  = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_last;
    logic        tx_ready;
    logic        rxm_rd, rxm_we, txm_rd, txm_we;
    logic [31:0] rxm_addr, rxm_wdata, rxm_rdata, txm_addr, txm_wdata, txm_rdata;
    logic [4:0]  flag_clr = '0;
    logic [4:0]  flags;

    logic [31:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [31:0] tb_addr = '0;
    logic [31:0] tb_data = '0;

    logic        stall_en = 1'b0;
    logic [3:0]  rdy_pat;

    logic [31:0] col_d [0:63];
    logic        col_l [0:63];
    int          col_n = 0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    dring_engine #(.BUF_WORDS(4)) dut_i (
        .clk(clk), .rst(rst), .rxq_base(rxq_base), .txq_base(txq_base),
        .tx_start(tx_start),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rxm_rd(rxm_rd), .rxm_we(rxm_we), .rxm_addr(rxm_addr), .rxm_wdata(rxm_wdata),
        .rxm_rdata(rxm_rdata),
        .txm_rd(txm_rd), .txm_we(txm_we), .txm_addr(txm_addr), .txm_wdata(txm_wdata),
        .txm_rdata(txm_rdata),
        .flag_clr(flag_clr), .flags(flags)
    );

    // memory model: same-cycle reads, writes at the clock edge
    assign rxm_rdata = mem[rxm_addr[9:2]];
    assign txm_rdata = mem[txm_addr[9:2]];

    always @(posedge clk) begin
        if (rxm_we) mem[rxm_addr[9:2]] <= rxm_wdata;
        if (txm_we) mem[txm_addr[9:2]] <= txm_wdata;
        if (tb_we)  mem[tb_addr[9:2]]  <= tb_data;
    end

    always @(posedge clk) begin
        if (rst) rdy_pat <= 4'b1011;
        else     rdy_pat <= {rdy_pat[0], rdy_pat[3:1]};
    end
    assign tx_ready = stall_en ? rdy_pat[0] : 1'b1;

    always @(negedge clk) begin
        if (tx_valid && tx_ready && col_n < 64) begin
            col_d[col_n] <= tx_data;
            col_l[col_n] <= tx_last;
            col_n <= col_n + 1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic clr_flags(input logic [4:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic rx_send(input int n, input logic [31:0] first);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = first + 32'(i);
            rx_last  = (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic tx_go();
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 flags in reset", 32'(flags), 32'h0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rx_ready idle", 32'(rx_ready), 32'h0);
        chk("R1 tx_valid idle", 32'(tx_valid), 32'h0);
        chk("R1 no writes", 32'({rxm_we, txm_we}), 32'h0);
    endtask

    task automatic t_setup();
        poke(32'h000, 32'h100); poke(32'h004, 0);
        poke(32'h008, 32'h140); poke(32'h00C, 0);
        poke(32'h010, 32'h182); poke(32'h014, 0);
        poke(32'h040, 32'h200); poke(32'h044, 32'h2);
        poke(32'h048, 32'h240); poke(32'h04C, 32'h8003);
        poke(32'h050, 32'h280); poke(32'h054, 32'hC000_0000);
        poke(32'h200, 32'hB000_0000); poke(32'h204, 32'hB000_0001);
        poke(32'h240, 32'hC000_0000); poke(32'h244, 32'hC000_0001);
        poke(32'h248, 32'hC000_0002);
    endtask

    task automatic t_rx_single();
        rx_send(3, 32'hA000_0010);
        chk("R2 word0", peek(32'h100), 32'hA000_0010);
        chk("R2 word1", peek(32'h104), 32'hA000_0011);
        chk("R2 word2", peek(32'h108), 32'hA000_0012);
        chk("R3 status sof eof len", peek(32'h004), 32'h0000_C003);
        chk("R2 ownership set", peek(32'h000), 32'h101);
        chk("R7 rx done flag", 32'(flags), 32'h04);
        clr_flags(5'h1F);
    endtask

    task automatic t_rx_span();
        rx_send(6, 32'hA000_0020);
        chk("R4 buffer1 first", peek(32'h140), 32'hA000_0020);
        chk("R4 buffer1 fourth", peek(32'h14C), 32'hA000_0023);
        chk("R3 middle status sof only", peek(32'h00C), 32'h0000_4000);
        chk("R2 buffer1 owned", peek(32'h008), 32'h141);
        chk("R4 buffer2 words", peek(32'h184), 32'hA000_0025);
        chk("R3 end status len6", peek(32'h014), 32'h0000_8006);
        chk("R2 wrap kept with own", peek(32'h010), 32'h183);
        clr_flags(5'h1F);
    endtask

    task automatic t_rx_nobuf_wrap();
        rx_send(2, 32'hA000_0030);
        chk("R6 no buffer flag", 32'(flags), 32'h08);
        chk("R6 nothing written", peek(32'h100), 32'hA000_0010);
        poke(32'h000, 32'h100);
        rx_send(1, 32'hA000_0040);
        chk("R5 rx wrapped to base", peek(32'h100), 32'hA000_0040);
        chk("R5 base status", peek(32'h004), 32'h0000_C001);
        clr_flags(5'h1F);
    endtask

    task automatic t_rx_ovr();
        poke(32'h008, 32'h140);
        rx_send(6, 32'hA000_0050);
        chk("R6 overrun and no buffer", 32'(flags), 32'h18);
        chk("R6 partial buffer", peek(32'h14C), 32'hA000_0053);
        chk("R3 partial status", peek(32'h00C), 32'h0000_4000);
        clr_flags(5'h1F);
    endtask

    task automatic t_tx_frame();
        int b;
        repeat (5) @(negedge clk);
        chk("R8 idle before start", 32'({tx_valid, txm_rd, txm_we}), 32'h0);
        stall_en = 1'b1;
        b = col_n;
        tx_go();
        chk("R9 word count", 32'(col_n - b), 32'd5);
        chk("R9 w0", col_d[b],   32'hB000_0000);
        chk("R9 w1", col_d[b+1], 32'hB000_0001);
        chk("R9 w2", col_d[b+2], 32'hC000_0000);
        chk("R9 w4", col_d[b+4], 32'hC000_0002);
        chk("R9 last marks", 32'({col_l[b], col_l[b+1], col_l[b+2], col_l[b+3], col_l[b+4]}), 32'h01);
        chk("R10 first handback", peek(32'h044), 32'h8000_0002);
        chk("R10 second handback", peek(32'h04C), 32'h8000_8003);
        chk("R10 tx done flag", 32'(flags), 32'h01);
        stall_en = 1'b0;
        clr_flags(5'h1F);
    endtask

    task automatic t_tx_zero_wrap();
        int b;
        poke(32'h054, 32'h4000_0000);
        poke(32'h044, 32'h0000_8001);
        b = col_n;
        tx_go();
        chk("R13 zero length handed back", peek(32'h054), 32'hC000_0000);
        chk("R5 tx wrap one word", 32'(col_n - b), 32'd1);
        chk("R5 tx wrap data", col_d[b], 32'hB000_0000);
        chk("R9 single last", 32'(col_l[b]), 32'h1);
        chk("R10 wrapped handback", peek(32'h044), 32'h8000_8001);
        chk("R10 done, no underrun", 32'(flags), 32'h01);
        clr_flags(5'h1F);
    endtask

    task automatic t_tx_und();
        int b;
        poke(32'h04C, 32'h0000_0001);
        b = col_n;
        tx_go();
        chk("R11 word sent", col_d[b], 32'hC000_0000);
        chk("R11 no last", 32'(col_l[b]), 32'h0);
        chk("R11 underrun flag", 32'(flags), 32'h02);
    endtask

    task automatic t_flags();
        clr_flags(5'h00);
        chk("R12 zero mask keeps", 32'(flags), 32'h02);
        clr_flags(5'h01);
        chk("R12 other bit keeps", 32'(flags), 32'h02);
        clr_flags(5'h02);
        chk("R12 cleared", 32'(flags), 32'h00);
    endtask

    initial begin
        t_reset();
        t_setup();
        t_rx_single();
        t_rx_span();
        t_rx_nobuf_wrap();
        t_rx_ovr();
        t_tx_frame();
        t_tx_zero_wrap();
        t_tx_und();
        t_flags();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule